// File: doc/BRIEF.md
# Doubleword Store Exception Checker

This block is the address and fault stage for a 64-bit store whose address is a base register plus an immediate offset. Each accepted request carries the base value, a 16-bit immediate, an optional upper-immediate prefix, the store data, the index of the source register, the current user-mode and virtual-mode bits, and three lookup flags computed outside the block: a translation miss, a no-access zone hit and a read-only zone hit.

The block forms the effective address and tests three fault conditions in a fixed order. If no fault fires, it issues one memory write. Otherwise it raises a one-cycle exception pulse that carries the new exception status fields. For the two memory-management faults, it also presents new machine status values together with a write strobe.

A parameter selects one of two timings. The fast timing takes two cycles and accepts a request every cycle. The area-optimised timing takes three cycles and holds `busy` while a request is in flight.

Top module: `st64_guard`

## Requirements
- R1: Without a prefix, `mem_addr` equals `base_val` plus `imm_lo` sign-extended to 64 bits, with wrap-around modulo 2^64, and `mem_wdata` equals `st_data`.
- R2: With `pfx_vld` high, the 64-bit offset is `{pfx_hi, imm_lo}` and takes no sign extension.
- R3: The faults are ranked translation miss first, protection fault second, misalignment third. Only the highest-ranked fault present is reported. `mem_we` pulses only when no fault is present.
- R4: While `mode_virt` is 0, `xl_miss`, `zone_noacc` and `zone_rdonly` have no effect.
- R5: A translation miss (`mode_virt`=1 and `xl_miss`=1) reports `esr_code`=5'b10010 and `esr_store`=1, with `esr_noacc`, `esr_size` and `esr_reg` all 0.
- R6: A protection fault reports `esr_code`=5'b10000 and `esr_store`=1. A protection fault is either `zone_rdonly` high, or `zone_noacc` high while `mode_user`=1. `esr_noacc` is 1 exactly when the fault comes from a no-access hit in user mode. `zone_noacc` is ignored while `mode_user`=0.
- R7: On a translation miss or a protection fault, `msr_wr` pulses. `msr_user_sv` carries the request's `mode_user`, `msr_virt_sv` carries its `mode_virt`, and `msr_user` and `msr_virt` are both 0.
- R8: A misalignment fault (any of `mem_addr[2:0]` nonzero) reports `esr_code`=5'b00001, `esr_size`=1, `esr_store`=1, `esr_reg`=`src_idx` and `esr_noacc`=0.
- R9: `msr_wr` stays 0 for a misalignment fault and for a store that completes without a fault.
- R10: Each accepted request produces exactly one single-cycle pulse, on either `mem_we` or `xcpt_pulse` and never on both.
- R11: If a request is presented in cycle 0, its result appears in cycle 1 with `AREA_OPT`=0 and in cycle 2 with `AREA_OPT`=1. The result appears in no other cycle.
- R12: With `AREA_OPT`=1, `busy` is high in the cycle after acceptance, and a request offered in that cycle is dropped. With `AREA_OPT`=0, `busy` is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request offered this cycle |
| busy | output | 1 | A new request is refused this cycle |
| base_val | input | 64 | Base register value |
| imm_lo | input | 16 | Immediate field |
| pfx_vld | input | 1 | An upper-immediate prefix applies |
| pfx_hi | input | 48 | Upper immediate bits from the prefix |
| st_data | input | 64 | Doubleword to store |
| src_idx | input | 5 | Index of the source register |
| mode_user | input | 1 | Current user-mode bit |
| mode_virt | input | 1 | Current virtual-mode bit |
| xl_miss | input | 1 | Translation lookup missed |
| zone_noacc | input | 1 | Address lies in a no-access zone |
| zone_rdonly | input | 1 | Address lies in a read-only zone |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 64 | Effective address |
| mem_wdata | output | 64 | Write data |
| xcpt_pulse | output | 1 | Exception raised; exception status fields valid |
| esr_code | output | 5 | Exception code |
| esr_store | output | 1 | Fault came from a store |
| esr_noacc | output | 1 | Protection fault came from a no-access zone |
| esr_size | output | 1 | Misaligned access was a doubleword |
| esr_reg | output | 5 | Source register of a misaligned store |
| msr_wr | output | 1 | Machine status write strobe |
| msr_user | output | 1 | New user-mode bit |
| msr_virt | output | 1 | New virtual-mode bit |
| msr_user_sv | output | 1 | New saved user-mode bit |
| msr_virt_sv | output | 1 | New saved virtual-mode bit |

## Verification
Directed vectors first place two or three faults together, so that the ranking is tested at each boundary. Miss plus protection plus misalignment checks that the miss wins. Protection plus misalignment checks that protection wins. Any fault flag with virtual mode off must fall through to the alignment test. A no-access flag in supervisor mode, set against one in user mode, tests the user-mode gating and the `esr_noacc` bit.

Address vectors walk each low address bit on its own, pair a negative immediate with and without a prefix to tell sign extension apart from prefix concatenation, and include a base near 2^64 to test wrap-around. Random vectors then mix all of these for both timings. A back-to-back pair tests that the three-cycle timing refuses the second request while the two-cycle timing accepts both.

// File: rtl/st64_pkg.sv
package st64_pkg;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_MISS = 2'd1,
    FK_PROT = 2'd2,
    FK_ALGN = 2'd3
  } fault_e;

  localparam logic [4:0] EC_XLMISS = 5'b10010;
  localparam logic [4:0] EC_PROT   = 5'b10000;
  localparam logic [4:0] EC_ALGN   = 5'b00001;

endpackage

// File: rtl/st64_ea.sv
module st64_ea #(
  parameter int AW = 64,
  parameter int IW = 16,
  parameter int LOWB = 3
) (
  input  logic [AW-1:0]    base,
  input  logic [IW-1:0]    imm,
  input  logic             pfx_vld,
  input  logic [AW-IW-1:0] pfx_hi,
  output logic [AW-1:0]    ea,
  output logic             misal
);
  localparam int PW = AW - IW;

  function automatic logic [AW-1:0] offset_of(input logic [IW-1:0] i,
                                              input logic p,
                                              input logic [PW-1:0] hi);
    logic [PW-1:0] upper;
    upper = p ? hi : {PW{i[IW-1]}};
    return {upper, i};
  endfunction

  assign ea    = base + offset_of(imm, pfx_vld, pfx_hi);
  assign misal = |ea[LOWB-1:0];
endmodule

// File: rtl/st64_prio.sv
module st64_prio
  import st64_pkg::*;
(
  input  logic   vm,
  input  logic   um,
  input  logic   miss,
  input  logic   noacc,
  input  logic   rdonly,
  input  logic   misal,
  output fault_e kind,
  output logic   diz
);
  logic noacc_hit;
  logic prot_hit;

  assign noacc_hit = vm & um & noacc;
  assign prot_hit  = noacc_hit | (vm & rdonly);
  assign diz       = noacc_hit;

  always_comb begin
    if (vm & miss)    kind = FK_MISS;
    else if (prot_hit) kind = FK_PROT;
    else if (misal)    kind = FK_ALGN;
    else               kind = FK_NONE;
  end
endmodule

// File: rtl/st64_guard.sv
module st64_guard
  import st64_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int IW = 16,
  parameter int RW = 5,
  parameter bit AREA_OPT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  output logic             busy,
  input  logic [AW-1:0]    base_val,
  input  logic [IW-1:0]    imm_lo,
  input  logic             pfx_vld,
  input  logic [AW-IW-1:0] pfx_hi,
  input  logic [DW-1:0]    st_data,
  input  logic [RW-1:0]    src_idx,
  input  logic             mode_user,
  input  logic             mode_virt,
  input  logic             xl_miss,
  input  logic             zone_noacc,
  input  logic             zone_rdonly,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             xcpt_pulse,
  output logic [4:0]       esr_code,
  output logic             esr_store,
  output logic             esr_noacc,
  output logic             esr_size,
  output logic [RW-1:0]    esr_reg,
  output logic             msr_wr,
  output logic             msr_user,
  output logic             msr_virt,
  output logic             msr_user_sv,
  output logic             msr_virt_sv
);
  localparam int PW  = AW - IW;
  localparam int LAT = AREA_OPT ? 3 : 2;

  typedef struct packed {
    logic          we;
    logic          xc;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [4:0]    ec;
    logic          s;
    logic          diz;
    logic          w;
    logic [RW-1:0] rx;
    logic          mwr;
    logic          um;
    logic          vm;
    logic          ums;
    logic          vms;
  } res_t;

  // capture stage
  logic          c_vld;
  logic [AW-1:0] c_base;
  logic [IW-1:0] c_imm;
  logic          c_pfx;
  logic [PW-1:0] c_hi;
  logic [DW-1:0] c_data;
  logic [RW-1:0] c_src;
  logic          c_um, c_vm, c_miss, c_noacc, c_rdonly;

  // named internal events
  logic          accept;
  logic [AW-1:0] ea;
  logic          misal;
  fault_e        fk;
  logic          diz;
  res_t          nxt, out;

  assign accept = rst_n & req_vld & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_vld    <= 1'b0;
      c_base   <= '0;
      c_imm    <= '0;
      c_pfx    <= 1'b0;
      c_hi     <= '0;
      c_data   <= '0;
      c_src    <= '0;
      c_um     <= 1'b0;
      c_vm     <= 1'b0;
      c_miss   <= 1'b0;
      c_noacc  <= 1'b0;
      c_rdonly <= 1'b0;
    end else begin
      c_vld <= accept;
      if (accept) begin
        c_base   <= base_val;
        c_imm    <= imm_lo;
        c_pfx    <= pfx_vld;
        c_hi     <= pfx_hi;
        c_data   <= st_data;
        c_src    <= src_idx;
        c_um     <= mode_user;
        c_vm     <= mode_virt;
        c_miss   <= xl_miss;
        c_noacc  <= zone_noacc;
        c_rdonly <= zone_rdonly;
      end
    end
  end

  st64_ea #(.AW(AW), .IW(IW), .LOWB(3)) u_ea (
    .base   (c_base),
    .imm    (c_imm),
    .pfx_vld(c_pfx),
    .pfx_hi (c_hi),
    .ea     (ea),
    .misal  (misal)
  );

  st64_prio u_prio (
    .vm    (c_vm),
    .um    (c_um),
    .miss  (c_miss),
    .noacc (c_noacc),
    .rdonly(c_rdonly),
    .misal (misal),
    .kind  (fk),
    .diz   (diz)
  );

  always_comb begin
    nxt = '0;
    if (c_vld) begin
      nxt.addr = ea;
      unique case (fk)
        FK_NONE: begin
          nxt.we   = 1'b1;
          nxt.data = c_data;
        end
        FK_MISS: begin
          nxt.xc  = 1'b1;
          nxt.ec  = EC_XLMISS;
          nxt.s   = 1'b1;
          nxt.mwr = 1'b1;
          nxt.ums = c_um;
          nxt.vms = c_vm;
        end
        FK_PROT: begin
          nxt.xc  = 1'b1;
          nxt.ec  = EC_PROT;
          nxt.s   = 1'b1;
          nxt.diz = diz;
          nxt.mwr = 1'b1;
          nxt.ums = c_um;
          nxt.vms = c_vm;
        end
        FK_ALGN: begin
          nxt.xc = 1'b1;
          nxt.ec = EC_ALGN;
          nxt.s  = 1'b1;
          nxt.w  = 1'b1;
          nxt.rx = c_src;
        end
        default: nxt = '0;
      endcase
    end
  end

  generate
    if (AREA_OPT) begin : g_slow
      res_t r_out;
      always_ff @(posedge clk) begin
        if (!rst_n) r_out <= '0;
        else        r_out <= nxt;
      end
      assign out  = r_out;
      assign busy = c_vld;
    end else begin : g_fast
      assign out  = nxt;
      assign busy = 1'b0;
    end
  endgenerate

  assign mem_we      = out.we;
  assign mem_addr    = out.addr;
  assign mem_wdata   = out.data;
  assign xcpt_pulse  = out.xc;
  assign esr_code    = out.ec;
  assign esr_store   = out.s;
  assign esr_noacc   = out.diz;
  assign esr_size    = out.w;
  assign esr_reg     = out.rx;
  assign msr_wr      = out.mwr;
  assign msr_user    = out.um;
  assign msr_virt    = out.vm;
  assign msr_user_sv = out.ums;
  assign msr_virt_sv = out.vms;
endmodule

// File: rtl/st64_guard_chk.sv
module st64_guard_chk #(
  parameter int LAT = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       busy,
  input logic       mem_we,
  input logic [2:0] addr_lo,
  input logic       xcpt,
  input logic [4:0] ec,
  input logic       esr_size,
  input logic       esr_store,
  input logic       msr_wr,
  input logic       msr_user,
  input logic       msr_virt
);
  // R10: write and exception are mutually exclusive
  p_we_vs_xcpt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !xcpt);

  // R11: one result per accepted request, LAT-1 cycles later
  p_result_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we | xcpt) == $past(accept, LAT-1));

  // R12: busy lasts one cycle and blocks acceptance
  p_busy_short_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  p_busy_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R3: a write never goes to a misaligned address
  p_write_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (addr_lo == 3'b000));

  // R7: mode bits cleared when machine status is written
  p_mode_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msr_wr |-> (xcpt && !msr_user && !msr_virt && esr_store));

  // R8 / R9: misalignment fault leaves machine status alone
  p_algn_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xcpt && ec == 5'b00001) |-> (esr_size && esr_store && !msr_wr));

  // R9: no machine status write without an exception
  p_msr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xcpt |-> !msr_wr);
endmodule

bind st64_guard st64_guard_chk #(.LAT(LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .busy     (busy),
  .mem_we   (mem_we),
  .addr_lo  (mem_addr[2:0]),
  .xcpt     (xcpt_pulse),
  .ec       (esr_code),
  .esr_size (esr_size),
  .esr_store(esr_store),
  .msr_wr   (msr_wr),
  .msr_user (msr_user),
  .msr_virt (msr_virt)
);

// File: tb/test_st64_guard.sv
module test_st64_guard;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] base;
    logic [15:0] imm;
    logic        pfx;
    logic [47:0] hi;
    logic [63:0] data;
    logic [4:0]  src;
    logic        um, vm, miss, noacc, rdonly;
  } vec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0;
  vec_t cur = '0;

  logic a_busy, a_we, a_xc, a_s, a_diz, a_w, a_mwr, a_um, a_vm, a_ums, a_vms;
  logic [63:0] a_addr, a_wdata;
  logic [4:0]  a_ec, a_rx;
  logic b_busy, b_we, b_xc, b_s, b_diz, b_w, b_mwr, b_um, b_vm, b_ums, b_vms;
  logic [63:0] b_addr, b_wdata;
  logic [4:0]  b_ec, b_rx;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  st64_guard i_st64_guard (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .busy(a_busy),
    .base_val(cur.base), .imm_lo(cur.imm), .pfx_vld(cur.pfx), .pfx_hi(cur.hi),
    .st_data(cur.data), .src_idx(cur.src), .mode_user(cur.um), .mode_virt(cur.vm),
    .xl_miss(cur.miss), .zone_noacc(cur.noacc), .zone_rdonly(cur.rdonly),
    .mem_we(a_we), .mem_addr(a_addr), .mem_wdata(a_wdata), .xcpt_pulse(a_xc),
    .esr_code(a_ec), .esr_store(a_s), .esr_noacc(a_diz), .esr_size(a_w), .esr_reg(a_rx),
    .msr_wr(a_mwr), .msr_user(a_um), .msr_virt(a_vm), .msr_user_sv(a_ums), .msr_virt_sv(a_vms)
  );

  st64_guard #(.AREA_OPT(1'b1)) i_st64_guard_ao (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .busy(b_busy),
    .base_val(cur.base), .imm_lo(cur.imm), .pfx_vld(cur.pfx), .pfx_hi(cur.hi),
    .st_data(cur.data), .src_idx(cur.src), .mode_user(cur.um), .mode_virt(cur.vm),
    .xl_miss(cur.miss), .zone_noacc(cur.noacc), .zone_rdonly(cur.rdonly),
    .mem_we(b_we), .mem_addr(b_addr), .mem_wdata(b_wdata), .xcpt_pulse(b_xc),
    .esr_code(b_ec), .esr_store(b_s), .esr_noacc(b_diz), .esr_size(b_w), .esr_reg(b_rx),
    .msr_wr(b_mwr), .msr_user(b_um), .msr_virt(b_vm), .msr_user_sv(b_ums), .msr_virt_sv(b_vms)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // model: 0 none, 1 miss, 2 protection, 3 misaligned
  function automatic logic [63:0] model_addr(input vec_t v);
    logic [63:0] off;
    if (v.pfx) off = {v.hi, v.imm};
    else       off = {{48{v.imm[15]}}, v.imm};
    return v.base + off;
  endfunction

  function automatic int model_kind(input vec_t v);
    logic [63:0] ad;
    ad = model_addr(v);
    if (v.vm && v.miss) return 1;
    if (v.vm && (v.rdonly || (v.noacc && v.um))) return 2;
    if (ad[2:0] != 3'b000) return 3;
    return 0;
  endfunction

  task automatic check_res(input string who, input vec_t v,
      input logic we, input logic xc, input logic [63:0] addr, input logic [63:0] wd,
      input logic [4:0] ec, input logic s, input logic diz, input logic w, input logic [4:0] rx,
      input logic mwr, input logic um, input logic vm, input logic ums, input logic vms);
    int k;
    k = model_kind(v);
    chk({who, " R10 single outcome"}, {62'd0, we, xc}, (k == 0) ? 64'd2 : 64'd1);
    chk({who, v.pfx ? " R2 address" : " R1 address"}, addr, model_addr(v));
    case (k)
      0: begin
        chk({who, " R1 wdata"}, wd, v.data);
        chk({who, " R9 msr idle on write"}, {63'd0, mwr}, 64'd0);
        if (!v.vm && (v.miss || v.noacc || v.rdonly))
          chk({who, " R4 flags ignored"}, {63'd0, we}, 64'd1);
      end
      1: begin
        chk({who, " R5 code"}, {59'd0, ec}, 64'h12);
        chk({who, " R5 fields"}, {60'd0, s, diz, w, |rx}, 64'h8);
        chk({who, " R7 msr"}, {59'd0, mwr, um, vm, ums, vms}, {59'd0, 1'b1, 1'b0, 1'b0, v.um, v.vm});
      end
      2: begin
        chk({who, " R6 code"}, {59'd0, ec}, 64'h10);
        chk({who, " R6 fields"}, {60'd0, s, diz, w, |rx}, {60'd0, 1'b1, v.noacc & v.um, 1'b0, 1'b0});
        chk({who, " R7 msr"}, {59'd0, mwr, um, vm, ums, vms}, {59'd0, 1'b1, 1'b0, 1'b0, v.um, v.vm});
      end
      default: begin
        chk({who, " R8 code"}, {59'd0, ec}, 64'h01);
        chk({who, " R8 fields"}, {56'd0, s, diz, w, rx}, {56'd0, 1'b1, 1'b0, 1'b1, v.src});
        chk({who, " R9 msr idle on misalign"}, {63'd0, mwr}, 64'd0);
      end
    endcase
  endtask

  task automatic check_a(input vec_t v);
    check_res("fast", v, a_we, a_xc, a_addr, a_wdata, a_ec, a_s, a_diz, a_w, a_rx,
              a_mwr, a_um, a_vm, a_ums, a_vms);
  endtask

  task automatic check_b(input vec_t v);
    check_res("slow", v, b_we, b_xc, b_addr, b_wdata, b_ec, b_s, b_diz, b_w, b_rx,
              b_mwr, b_um, b_vm, b_ums, b_vms);
  endtask

  // single request: fast result in cycle 1, slow result in cycle 2
  task automatic run_vec(input vec_t v);
    @(negedge clk);
    cur = v;
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    check_a(v);
    chk("slow R11 no early result", {62'd0, b_we, b_xc}, 64'd0);
    chk("slow R12 busy after accept", {63'd0, b_busy}, 64'd1);
    chk("fast R12 never busy", {63'd0, a_busy}, 64'd0);
    @(negedge clk);
    check_b(v);
    chk("fast R11 no late result", {62'd0, a_we, a_xc}, 64'd0);
    @(negedge clk);
    chk("slow R11 single result", {62'd0, b_we, b_xc}, 64'd0);
  endtask

  function automatic vec_t mk(input logic [63:0] base, input logic [15:0] imm,
                              input logic pfx, input logic [47:0] hi,
                              input logic um, input logic vm, input logic miss,
                              input logic noacc, input logic rdonly);
    vec_t v;
    v.base = base; v.imm = imm; v.pfx = pfx; v.hi = hi;
    v.data = {base[31:0] ^ 32'hA5A5_5A5A, 16'hBEEF, imm};
    v.src = base[8:4] ^ 5'd9;
    v.um = um; v.vm = vm; v.miss = miss; v.noacc = noacc; v.rdonly = rdonly;
    return v;
  endfunction

  function automatic vec_t rnd_vec();
    vec_t v;
    v.base   = {$urandom, $urandom};
    v.imm    = 16'($urandom);
    if ($urandom_range(1, 0) == 0) begin
      v.base[2:0] = 3'b000;
      v.imm[2:0]  = 3'b000;
    end
    v.pfx    = ($urandom_range(9, 0) < 3);
    v.hi     = {16'($urandom), $urandom};
    v.data   = {$urandom, $urandom};
    v.src    = 5'($urandom);
    v.um     = 1'($urandom);
    v.vm     = 1'($urandom);
    v.miss   = ($urandom_range(3, 0) == 0);
    v.noacc  = ($urandom_range(3, 0) == 0);
    v.rdonly = ($urandom_range(3, 0) == 0);
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    vec_t v1, v2;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("fast R10 reset idle", {62'd0, a_we, a_xc}, 64'd0);
    chk("slow R10 reset idle", {62'd0, b_we, b_xc}, 64'd0);
    chk("slow R12 reset not busy", {63'd0, b_busy}, 64'd0);
    rst_n = 1'b1;

    // R1 plain aligned store, positive and negative immediates
    run_vec(mk(64'h0000_1000_0000_0100, 16'h0008, 0, 48'h0, 1, 1, 0, 0, 0));
    run_vec(mk(64'h0000_1000_0000_0100, 16'hFFF8, 0, 48'h0, 0, 0, 0, 0, 0));
    // R1 wrap around
    run_vec(mk(64'hFFFF_FFFF_FFFF_FFF8, 16'h0010, 0, 48'h0, 0, 0, 0, 0, 0));
    // R2 prefix replaces sign extension
    run_vec(mk(64'h0000_0000_0000_1000, 16'h8000, 1, 48'h0000_0000_0001, 0, 0, 0, 0, 0));
    run_vec(mk(64'h0000_0000_0000_1000, 16'h8000, 1, 48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 0));
    // R3 ranking: miss over protection and misalignment
    run_vec(mk(64'h0000_0000_0000_2003, 16'h0000, 0, 48'h0, 1, 1, 1, 1, 1));
    // R3 ranking: protection over misalignment
    run_vec(mk(64'h0000_0000_0000_2005, 16'h0000, 0, 48'h0, 0, 1, 0, 0, 1));
    // R4 all flags with virtual mode off: store proceeds, or misaligned
    run_vec(mk(64'h0000_0000_0000_3000, 16'h0000, 1, 48'h0, 1, 0, 1, 1, 1));
    run_vec(mk(64'h0000_0000_0000_3002, 16'h0000, 1, 48'h0, 1, 0, 1, 1, 1));
    // R5 miss alone, supervisor
    run_vec(mk(64'h0000_0000_0000_4000, 16'h0000, 0, 48'h0, 0, 1, 1, 0, 0));
    // R6 no-access in supervisor ignored, in user reported
    run_vec(mk(64'h0000_0000_0000_5000, 16'h0000, 0, 48'h0, 0, 1, 0, 1, 0));
    run_vec(mk(64'h0000_0000_0000_5000, 16'h0000, 0, 48'h0, 1, 1, 0, 1, 0));
    run_vec(mk(64'h0000_0000_0000_5000, 16'h0000, 0, 48'h0, 1, 1, 0, 1, 1));
    // R8 each low address bit alone
    for (int b = 0; b < 3; b++)
      run_vec(mk(64'h0000_0000_0000_6000 | (64'd1 << b), 16'h0000, 0, 48'h0, 1, 1, 0, 0, 0));
    // R8 misalignment produced by the immediate
    run_vec(mk(64'h0000_0000_0000_6000, 16'hFFFF, 0, 48'h0, 0, 0, 0, 0, 0));

    // R12 back-to-back: slow drops the second request, fast takes both
    v1 = mk(64'h0000_0000_0000_7000, 16'h0008, 0, 48'h0, 0, 0, 0, 0, 0);
    v2 = mk(64'h0000_0000_0000_7001, 16'h0000, 0, 48'h0, 0, 0, 0, 0, 0);
    @(negedge clk);
    cur = v1; req_vld = 1'b1;
    @(negedge clk);
    check_a(v1);
    chk("slow R12 busy", {63'd0, b_busy}, 64'd1);
    cur = v2;
    @(negedge clk);
    req_vld = 1'b0;
    check_a(v2);
    check_b(v1);
    @(negedge clk);
    chk("slow R12 second request dropped", {62'd0, b_we, b_xc}, 64'd0);
    chk("fast R11 idle after pair", {62'd0, a_we, a_xc}, 64'd0);

    // random mix
    for (int n = 0; n < 400; n++) run_vec(rnd_vec());

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule